// File: doc/BRIEF.md
# Dual-Pin Interrupt Routing Controller

This block gathers eight interrupt sources from the detection logic and the sample buffer of a motion sensor. It routes each source to one of two active-high interrupt pins. There are two kinds of source. Three are data-related: data ready, watermark and overrun. These arrive as condition levels, and their flags simply follow the level. They drop once reads of sample data remove the condition. The other five are event sources: single tap, double tap, activity, inactivity and free fall. These arrive as one-cycle pulses. Each pulse sets a sticky flag that holds until software reads the status register.

Software controls routing through two registers on a small synchronous read/write port. The enable register gates each source. The map register picks the pin for each source. A status register shows the raw flags, whether or not they are enabled. Software should write zero to the enable register before it changes the routing, so that no spurious interrupt appears during the change. Both pins are driven from flops. Several sources may share one pin, and that pin is the OR of them.

Top module: `irq_route_top`

## Requirements
- R1: After reset, the enable register, the map register and every flag read as zero, and both pins are low.
- R2: A write to address 0 loads the enable register and a write to address 1 loads the map register. A read of either address returns its contents one cycle later on `reg_rdata`.
- R3: Address 2 reads the raw flag vector, whether or not the sources are enabled. The bit positions are: bit 7 data ready, bit 6 single tap, bit 5 double tap, bit 4 activity, bit 3 inactivity, bit 2 free fall, bit 1 watermark, bit 0 overrun.
- R4: A one-cycle pulse on an event input (bits 6..2) sets its flag, and the flag holds for as long as no status read occurs.
- R5: A read of address 2 returns the flags as they were before the read, and it clears every event flag.
- R6: An event pulse that arrives in the same cycle as a status read leaves its flag set after the read.
- R7: A data-related flag (bits 7, 1, 0) equals its condition input one cycle later. A status read does not clear it.
- R8: A map bit of 0 sends its source to `irq1_o` and a map bit of 1 sends it to `irq2_o`. Each pin is the OR of all enabled flags mapped to it.
- R9: A source whose enable bit is 0 never raises a pin. An enable value of zero holds both pins low.
- R10: Each pin changes one cycle after the flag or configuration change that causes it.
- R11: A read of address 3 returns zero, and a write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 8 | Condition levels (bits 7,1,0) and event pulses (bits 6..2) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq1_o | output | 1 | First interrupt pin, active high |
| irq2_o | output | 1 | Second interrupt pin, active high |

## Verification
The vector table sets enable and map together with a source pattern. The patterns are a single source on each pin, all sources enabled, all sources disabled, enable bits that miss the active sources, and mixed masks that split the sources across both pins. These separate the enable gating from the map selection and from the OR merge. Directed tests then compare the two clearing rules: an event flag is held over idle cycles and a data-related flag is held across repeated status reads. One test collides a pulse with a status read. The remaining tests measure pin latency after a new flag and after the enable register is cleared.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int SRC_W      = 8;
   localparam int ADDR_ENA   = 0;
   localparam int ADDR_MAP   = 1;
   localparam int ADDR_STAT  = 2;
   // bit positions of the sources
   localparam int B_DRDY     = 7;
   localparam int B_TAP1     = 6;
   localparam int B_TAP2     = 5;
   localparam int B_ACT      = 4;
   localparam int B_INACT    = 3;
   localparam int B_FALL     = 2;
   localparam int B_WMARK    = 1;
   localparam int B_OVRN     = 0;
   localparam logic [SRC_W-1:0] LEVEL_MASK_DEF =
      (8'd1 << B_DRDY) | (8'd1 << B_WMARK) | (8'd1 << B_OVRN);
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
   parameter int SRC_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [SRC_W-1:0]  wdata,
   output logic [SRC_W-1:0]  ena_q,
   output logic [SRC_W-1:0]  map_q
);
   localparam logic [ADDR_W-1:0] A_ENA = ADDR_W'(irq_route_pkg::ADDR_ENA);
   localparam logic [ADDR_W-1:0] A_MAP = ADDR_W'(irq_route_pkg::ADDR_MAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= '0;
         map_q <= '0;
      end else if (wr) begin
         if (addr == A_ENA) ena_q <= wdata;
         if (addr == A_MAP) map_q <= wdata;
      end
   end
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags #(
   parameter int               SRC_W      = 8,
   parameter logic [SRC_W-1:0] LEVEL_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   input  logic             clr_evt,
   output logic [SRC_W-1:0] flags_q
);
   for (genvar b = 0; b < SRC_W; b++) begin : g_bit
      if (LEVEL_MASK[b]) begin : g_level
         // follows the condition level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[b] <= 1'b0;
            else        flags_q[b] <= src[b];
         end
      end else begin : g_sticky
         // set by a pulse, cleared by status read; a new pulse wins
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags_q[b] <= 1'b0;
            else        flags_q[b] <= (flags_q[b] & ~clr_evt) | src[b];
         end
      end
   end
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
   parameter int SRC_W  = 8,
   parameter int PINS   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] flags,
   input  logic [SRC_W-1:0] ena,
   input  logic [SRC_W-1:0] map,
   output logic [PINS-1:0]  pin_q
);
   logic [SRC_W-1:0] live;
   assign live = flags & ena;

   for (genvar p = 0; p < PINS; p++) begin : g_pin
      logic [SRC_W-1:0] sel;
      if (p == 0) begin : g_first
         assign sel = ~map;
      end else begin : g_second
         assign sel = map;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q[p] <= 1'b0;
         else        pin_q[p] <= |(live & sel);
      end
   end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
   parameter int                SRC_W      = irq_route_pkg::SRC_W,
   parameter int                ADDR_W     = 2,
   parameter logic [SRC_W-1:0]  LEVEL_MASK = irq_route_pkg::LEVEL_MASK_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  src_in,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [SRC_W-1:0]  reg_wdata,
   output logic [SRC_W-1:0]  reg_rdata,
   output logic              irq1_o,
   output logic              irq2_o
);
   localparam int PINS = 2;
   localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(irq_route_pkg::ADDR_ENA);
   localparam logic [ADDR_W-1:0] A_MAP  = ADDR_W'(irq_route_pkg::ADDR_MAP);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(irq_route_pkg::ADDR_STAT);

   if (SRC_W < 1 || SRC_W > 32) begin : g_bad_width
      $error("irq_route_top: SRC_W out of range");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("irq_route_top: ADDR_W must hold three registers");
   end

   logic [SRC_W-1:0] ena_q, map_q, flags_q, rdata_q;
   logic [PINS-1:0]  pin_q;
   logic             status_rd;

   assign status_rd = reg_rd && (reg_addr == A_STAT);

   irq_cfg_regs #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .ena_q(ena_q), .map_q(map_q));

   irq_src_flags #(.SRC_W(SRC_W), .LEVEL_MASK(LEVEL_MASK)) u_flags (
      .clk(clk), .rst_n(rst_n), .src(src_in), .clr_evt(status_rd),
      .flags_q(flags_q));

   irq_pin_drive #(.SRC_W(SRC_W), .PINS(PINS)) u_pins (
      .clk(clk), .rst_n(rst_n), .flags(flags_q), .ena(ena_q),
      .map(map_q), .pin_q(pin_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else if (reg_rd) begin
         unique case (reg_addr)
            A_ENA:   rdata_q <= ena_q;
            A_MAP:   rdata_q <= map_q;
            A_STAT:  rdata_q <= flags_q;
            default: rdata_q <= '0;
         endcase
      end
   end

   assign reg_rdata = rdata_q;
   assign irq1_o    = pin_q[0];
   assign irq2_o    = pin_q[1];
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
   parameter int               SRC_W      = 8,
   parameter logic [SRC_W-1:0] LEVEL_MASK = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SRC_W-1:0] src_in,
   input logic [SRC_W-1:0] flags,
   input logic [SRC_W-1:0] ena,
   input logic [SRC_W-1:0] map,
   input logic             status_rd,
   input logic             irq1,
   input logic             irq2
);
   localparam logic [SRC_W-1:0] EVT_MASK = ~LEVEL_MASK;

   // R4 / R6: a pulse always leaves its flag set, even beside a status read
   p_evt_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_in & EVT_MASK) != '0 |=> (flags & $past(src_in & EVT_MASK)) == $past(src_in & EVT_MASK));

   // R5: a read with no new pulse empties the event flags
   p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd && (src_in & EVT_MASK) == '0 |=> (flags & EVT_MASK) == '0);

   // R7: data-related flags follow their condition
   p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (flags & LEVEL_MASK) == $past(src_in & LEVEL_MASK));

   // R8 / R10: pin one follows enabled flags mapped low
   p_pin1_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq1 == $past(|(flags & ena & ~map)));

   p_pin2_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq2 == $past(|(flags & ena & map)));

   // R9: nothing enabled, no pin
   p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ena == '0 |=> !irq1 && !irq2);
endmodule

bind irq_route_top irq_route_chk #(.SRC_W(SRC_W), .LEVEL_MASK(LEVEL_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_in(src_in), .flags(flags_q),
   .ena(ena_q), .map(map_q), .status_rd(status_rd),
   .irq1(irq1_o), .irq2(irq2_o));

// File: tb/irq_route_top_tb_top.sv
`timescale 1ns/1ps
module irq_route_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] src_in = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq1_o, irq2_o;
   int         n_chk = 0, n_bad = 0;

   localparam logic [7:0] LVL = 8'b1000_0011;

   always #10 clk = ~clk;

   irq_route_top dut_i (.*);

   // {enable, map, sources}
   localparam int NV = 8;
   localparam logic [23:0] VEC [NV] = '{
      {8'hFF, 8'h00, 8'h80}, {8'hFF, 8'hFF, 8'h40},
      {8'h00, 8'h00, 8'hFF}, {8'h0F, 8'hF0, 8'hF0},
      {8'hA5, 8'h3C, 8'hFF}, {8'hFF, 8'h55, 8'h03},
      {8'h12, 8'h12, 8'h12}, {8'h81, 8'h01, 8'h81}};

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc(1);
      reg_wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a, output logic [7:0] d);
      reg_rd = 1'b1; reg_addr = a;
      cyc(1);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic [1:0] pins(input logic [7:0] s, e, m);
      return {|(s & e & m), |(s & e & ~m)};
   endfunction

   initial begin
      #(20ns * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      chk("R1 pins", {6'd0, irq2_o, irq1_o}, 8'h00);
      rreg(2'd0, rd); chk("R1 enable", rd, 8'h00);
      rreg(2'd1, rd); chk("R1 map", rd, 8'h00);
      rreg(2'd2, rd); chk("R1 status", rd, 8'h00);

      // table walk: R3 raw status, R8 routing, R9 gating
      for (int v = 0; v < NV; v++) begin
         logic [7:0] e, m, s;
         {e, m, s} = VEC[v];
         wreg(2'd0, 8'h00);
         wreg(2'd1, m);
         wreg(2'd0, e);
         src_in = s;
         cyc(1);
         src_in = s & LVL;
         cyc(1);
         chk("R8 R9 pins", {6'd0, pins(s, e, m)}, {6'd0, irq2_o, irq1_o});
         src_in = '0;
         rreg(2'd2, rd); chk("R3 status raw", rd, s);
         cyc(1);
         chk("R5 pins after clear", {6'd0, irq2_o, irq1_o}, 8'h00);
      end

      // R2 readback
      wreg(2'd0, 8'h5A); wreg(2'd1, 8'hC3);
      rreg(2'd0, rd); chk("R2 enable", rd, 8'h5A);
      rreg(2'd1, rd); chk("R2 map", rd, 8'hC3);
      // R11 unused address
      wreg(2'd3, 8'hFF);
      rreg(2'd3, rd); chk("R11 read zero", rd, 8'h00);
      rreg(2'd0, rd); chk("R11 enable kept", rd, 8'h5A);
      rreg(2'd1, rd); chk("R11 map kept", rd, 8'hC3);

      // R4 hold over idle cycles, R10 latency
      wreg(2'd0, 8'hFF); wreg(2'd1, 8'h00);
      src_in = 8'h40; cyc(1); src_in = '0;
      chk("R10 pin not yet", {7'd0, irq1_o}, 8'h00);
      cyc(1);
      chk("R10 pin up", {7'd0, irq1_o}, 8'h01);
      cyc(6);
      rreg(2'd2, rd); chk("R4 held", rd, 8'h40);
      rreg(2'd2, rd); chk("R5 cleared", rd, 8'h00);

      // R6 pulse colliding with status read
      src_in = 8'h10; cyc(1); src_in = '0;
      src_in = 8'h10; rreg(2'd2, rd); src_in = '0;
      chk("R6 old value", rd, 8'h10);
      rreg(2'd2, rd); chk("R6 kept", rd, 8'h10);
      rreg(2'd2, rd); chk("R6 then cleared", rd, 8'h00);

      // R7 level flag survives reads
      src_in = 8'h80; cyc(1);
      rreg(2'd2, rd); chk("R7 first read", rd, 8'h80);
      rreg(2'd2, rd); chk("R7 second read", rd, 8'h80);
      chk("R7 pin", {7'd0, irq1_o}, 8'h01);
      src_in = '0; cyc(1);
      rreg(2'd2, rd); chk("R7 follows drop", rd, 8'h00);

      // R9 enable off drops pin one cycle after the write
      src_in = 8'h04; cyc(1); src_in = '0; cyc(1);
      chk("R9 pin on", {7'd0, irq1_o}, 8'h01);
      wreg(2'd0, 8'h00);
      chk("R10 pin lags write", {7'd0, irq1_o}, 8'h01);
      cyc(1);
      chk("R9 pin off", {7'd0, irq1_o}, 8'h00);
      rreg(2'd2, rd); chk("R3 raw while disabled", rd, 8'h04);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule